// File: doc/BRIEF.md
# Four-Stage Keyed Watchdog Timer

This block is a watchdog timer. Its timeout runs through four stages in a fixed order, and each stage has its own tick limit and its own expiry action. When a stage runs out, the block can do nothing, raise an interrupt, send a reset pulse to the CPU, send a reset pulse to the system, or send a reset pulse to the always-on domain. Software restarts the sequence by feeding the watchdog. If software stops feeding, the stages run out one after another and the programmed actions happen in turn.

Every register is reached through a single write port. Only the key register accepts writes at all times. The other registers take a write only after the 32-bit unlock key has been written to the key register. The stage-0 limit is scaled up by a 2-bit delay selector that comes from outside the block. A sleep input can freeze counting when the control word asks for that.

Top module: `keyed_stage_wdt`

## Requirements
- R1: After reset the registers are locked. Writing 0x50D83AA1 to address 0 unlocks them, and writing any other value there, including 0, locks them again. A write to addresses 1 to 6 while locked is ignored.
- R2: The control word is at address 1, and its bit 0 is the enable. While the enable is 0 the stage is 0 and the count is 0. Counting begins on the first clock after the enable is set.
- R3: Each stage lasts a number of active cycles equal to its limit. A limit of 0 counts as 1. The limits for stages 0 to 3 are at addresses 2 to 5. Stages run 0→1→2→3. After stage 3 runs out, counting stops until the watchdog is fed or disabled.
- R4: The stage-0 limit is the programmed value shifted left by (1 + delay_sel).
- R5: The 3-bit action codes are at control bits [11:9], [14:12], [17:15] and [20:18] for stages 0 to 3. The codes are: 0 none, 1 interrupt, 2 CPU reset, 3 system reset, 4 always-on reset, and 5 to 7 none. A stage with no action still runs out and hands over to the next stage.
- R6: The interrupt status bit sets when a stage with action 1 runs out. `irq` equals status AND the interrupt enable, which is control bit 2. Writing address 6 with bit 1 set clears the status. If a set and a clear happen in the same cycle, the set wins.
- R7: The reset pulse widths use 3-bit codes. The CPU code is at control bits [5:3]. The system code is at bits [8:6], and the always-on pulse uses the system code as well. Codes 0 to 7 mean 100, 200, 300, 400, 500, 800, 1600 and 3200 ns. The pulse lasts ceil(ns / CLK_PERIOD_NS) cycles, with a minimum of one cycle.
- R8: A reset request that arrives while the same output's pulse is still high is dropped.
- R9: Writing address 6 with bit 0 set feeds the watchdog: the stage returns to 0 and the count to 0. A feed written while the registers are locked is ignored.
- R10: When the pause bit (control bit 1) and `sleep_in` are both high, the count and the stage hold. When the pause bit is clear, `sleep_in` has no effect.
- R11: During reset, `irq`, `cpu_rst`, `sys_rst` and `aon_rst` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 32 | Write data |
| sleep_in | input | 1 | Sleep indication |
| delay_sel | input | 2 | Stage-0 scale selector |
| irq | output | 1 | Interrupt (status AND enable) |
| cpu_rst | output | 1 | CPU reset pulse |
| sys_rst | output | 1 | System reset pulse |
| aon_rst | output | 1 | Always-on domain reset pulse |

## Verification
A feed takes effect on the clock edge that samples it. A stage with effective limit L then runs out on the L-th active edge after that, and `irq` or the reset output changes on that same edge. The bench drives and samples on falling edges, and it counts falling edges from the end of the feed write, so every timeout should be seen at exactly the computed count. Status clears and control writes reach `irq` on the edge that samples the write. A reset pulse is measured as the number of falling edges on which the output is high, which should equal the computed width.

// File: rtl/keyed_stage_wdt.sv
module keyed_stage_wdt #(
  parameter int          CLK_PERIOD_NS = 5,
  parameter int          CNT_W         = 32,
  parameter logic [31:0] UNLOCK_KEY    = 32'h50D83AA1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic        sleep_in,
  input  logic [1:0]  delay_sel,
  output logic        irq,
  output logic        cpu_rst,
  output logic        sys_rst,
  output logic        aon_rst
);
  localparam logic [2:0] A_KEY  = 3'd0;
  localparam logic [2:0] A_CTRL = 3'd1;
  localparam logic [2:0] A_LIM0 = 3'd2;
  localparam logic [2:0] A_CMD  = 3'd6;
  localparam int EW = CNT_W + 4;
  localparam int PW = $clog2((3200 + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS + 1);

  function automatic logic [PW-1:0] width_of(input logic [2:0] code);
    int ns, c;
    case (code)
      3'd0: ns = 100;  3'd1: ns = 200;  3'd2: ns = 300;  3'd3: ns = 400;
      3'd4: ns = 500;  3'd5: ns = 800;  3'd6: ns = 1600; default: ns = 3200;
    endcase
    c = (ns + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
    if (c < 1) c = 1;
    return PW'(c);
  endfunction

  logic             unlocked;
  logic [20:0]      ctrl;
  logic [CNT_W-1:0] lim [4];
  logic [CNT_W-1:0] cnt;
  logic [1:0]       stage;
  logic             spent;
  logic             irq_st;
  logic [PW-1:0]    pcnt [3];
  logic [2:0]       act;
  logic [CNT_W-1:0] cur_lim;
  logic [EW-1:0]    eff_lim;

  wire cfg_wr  = wr_en && unlocked;
  wire feed    = cfg_wr && wr_addr == A_CMD && wr_data[0];
  wire clr     = cfg_wr && wr_addr == A_CMD && wr_data[1];
  wire en      = ctrl[0];
  wire pause   = ctrl[1];
  wire irq_en  = ctrl[2];
  wire active  = en && !spent && !(pause && sleep_in);

  assign cur_lim = (lim[stage] == '0) ? CNT_W'(1) : lim[stage];
  assign eff_lim = (stage == 2'd0) ? (EW'(cur_lim) << ({1'b0, delay_sel} + 3'd1))
                                   : EW'(cur_lim);
  wire expire = active && ((EW'(cnt) + EW'(1)) >= eff_lim);

  always_comb begin
    case (stage)
      2'd0:    act = ctrl[11:9];
      2'd1:    act = ctrl[14:12];
      2'd2:    act = ctrl[17:15];
      default: act = ctrl[20:18];
    endcase
  end

  wire       fire_irq = expire && act == 3'd1;
  wire [2:0] req      = {expire && act == 3'd4, expire && act == 3'd3, expire && act == 3'd2};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) unlocked <= 1'b0;
    else if (wr_en && wr_addr == A_KEY) unlocked <= (wr_data == UNLOCK_KEY);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
      for (int i = 0; i < 4; i++) lim[i] <= '0;
    end else if (cfg_wr) begin
      if (wr_addr == A_CTRL) ctrl <= wr_data[20:0];
      for (int i = 0; i < 4; i++)
        if (wr_addr == A_LIM0 + 3'(i)) lim[i] <= wr_data[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; stage <= 2'd0; spent <= 1'b0;
    end else if (!en || feed) begin
      cnt <= '0; stage <= 2'd0; spent <= 1'b0;
    end else if (expire) begin
      cnt <= '0;
      if (stage == 2'd3) spent <= 1'b1;
      else stage <= stage + 2'd1;
    end else if (active) begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_st <= 1'b0;
    else if (fire_irq) irq_st <= 1'b1;
    else if (clr) irq_st <= 1'b0;
  end

  for (genvar j = 0; j < 3; j++) begin : g_pulse
    wire [2:0] code = (j == 0) ? ctrl[5:3] : ctrl[8:6];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pcnt[j] <= '0;
      else if (pcnt[j] != '0) pcnt[j] <= pcnt[j] - PW'(1);
      else if (req[j]) pcnt[j] <= width_of(code);
    end
    assert_pulse_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (pcnt[j] != '0) |=> (pcnt[j] == $past(pcnt[j]) - PW'(1)));
  end

  assign irq     = irq_st && irq_en;
  assign cpu_rst = pcnt[0] != '0;
  assign sys_rst = pcnt[1] != '0;
  assign aon_rst = pcnt[2] != '0;

  assert_locked_ctrl_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !unlocked && wr_addr == A_CTRL) |=> $stable(ctrl));
  assert_disabled_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt == '0 && stage == 2'd0));
  assert_stage_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (stage == $past(stage) || stage == 2'd0 || stage == $past(stage) + 2'd1));
  assert_spent_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (spent && en && !feed) |=> (stage == 2'd3 && cnt == '0));
  assert_pause_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (en && pause && sleep_in && !feed) |=> ($stable(cnt) && $stable(stage)));
endmodule

// File: tb/tb_keyed_stage_wdt.sv
`timescale 1ns/1ps
module tb_keyed_stage_wdt;
  localparam logic [31:0] KEY = 32'h50D83AA1;
  logic clk = 0, rst_n = 0, wr_en = 0, sleep_in = 0;
  logic [2:0] wr_addr = 0;
  logic [31:0] wr_data = 0;
  logic [1:0] delay_sel = 0;
  logic irq, cpu_rst, sys_rst, aon_rst;
  int tests = 0, fails = 0;
  bit done = 0;

  keyed_stage_wdt dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sleep_in(sleep_in), .delay_sel(delay_sel), .irq(irq),
    .cpu_rst(cpu_rst), .sys_rst(sys_rst), .aon_rst(aon_rst));

  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input bit en, input bit pz, input bit ie,
      input logic [2:0] cl, input logic [2:0] sl, input logic [2:0] a0,
      input logic [2:0] a1, input logic [2:0] a2, input logic [2:0] a3);
    return {11'd0, a3, a2, a1, a0, sl, cl, ie, pz, en};
  endfunction

  function automatic int expw(input int code);
    int ns [8] = '{100, 200, 300, 400, 500, 800, 1600, 3200};
    return (ns[code] + 4) / 5;
  endfunction

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic setup(input logic [31:0] c, input int l0, input int l1, input int l2, input int l3);
    wr(3'd1, c & ~32'd1);
    wr(3'd2, l0); wr(3'd3, l1); wr(3'd4, l2); wr(3'd5, l3);
    wr(3'd6, 32'd2);
    wr(3'd1, c | 32'd1);
    wr(3'd6, 32'd1);
  endtask

  task automatic wait_irq(input int mx, output int n);
    n = 0;
    while (!irq && n < mx) begin @(negedge clk); n++; end
  endtask

  task automatic measure(input int which, output int start, output int width);
    logic s;
    start = 0; width = 0;
    s = (which == 0) ? cpu_rst : (which == 1) ? sys_rst : aon_rst;
    while (!s && start < 100) begin
      @(negedge clk); start++;
      s = (which == 0) ? cpu_rst : (which == 1) ? sys_rst : aon_rst;
    end
    while (s && width < 1000) begin
      @(negedge clk); width++;
      s = (which == 0) ? cpu_rst : (which == 1) ? sys_rst : aon_rst;
    end
  endtask

  initial begin
    int n, st, w, hi, rises;
    logic prev;
    logic [3:0] seen, expv;
    idle(3);
    check({irq, cpu_rst, sys_rst, aon_rst} == 4'b0, "R11 reset outputs", {irq, cpu_rst, sys_rst, aon_rst}, 0);
    rst_n = 1;
    idle(2);

    wr(3'd1, mk(1, 0, 1, 0, 0, 1, 0, 0, 0));
    wr(3'd6, 32'd1);
    idle(30);
    check(irq == 0, "R1 locked after reset", irq, 0);
    wr(3'd0, KEY);

    for (int d = 0; d < 4; d++)
      for (int l = 1; l <= 3; l++) begin
        delay_sel = 2'(d);
        setup(mk(1, 0, 1, 0, 0, 1, 0, 0, 0), l, 1, 1, 1);
        wait_irq(200, n);
        check(n == (l << (1 + d)), "R4 stage0 scaling", n, l << (1 + d));
      end
    delay_sel = 0;

    setup(mk(1, 0, 1, 0, 0, 1, 0, 0, 0), 0, 1, 1, 1);
    wait_irq(50, n);
    check(n == 2, "R3 zero limit acts as one", n, 2);

    setup(mk(1, 0, 1, 0, 0, 0, 0, 0, 1), 2, 3, 4, 5);
    wait_irq(100, n);
    check(n == 16, "R3 chained stages R5 off stages advance", n, 16);
    wr(3'd6, 32'd2);
    idle(60);
    check(irq == 0, "R3 stays after stage3", irq, 0);

    setup(mk(1, 0, 1, 0, 0, 0, 1, 0, 0), 3, 5, 9, 9);
    wait_irq(100, n);
    check(n == 11, "R3 stage1 timing", n, 11);

    for (int code = 0; code < 8; code++) begin
      setup(mk(1, 0, 1, 0, 0, 3'(code), 0, 0, 0), 1, 1, 1, 1);
      seen = 0;
      for (int i = 0; i < 40; i++) begin
        seen |= {aon_rst, sys_rst, cpu_rst, irq};
        @(negedge clk);
      end
      expv = (code == 1) ? 4'b0001 : (code == 2) ? 4'b0010 :
             (code == 3) ? 4'b0100 : (code == 4) ? 4'b1000 : 4'b0000;
      check(seen == expv, "R5 action decode", seen, expv);
    end

    setup(mk(1, 0, 0, 0, 0, 1, 0, 0, 0), 3, 1, 1, 1);
    idle(20);
    check(irq == 0, "R6 masked irq", irq, 0);
    wr(3'd1, mk(1, 0, 1, 0, 0, 1, 0, 0, 0));
    check(irq == 1, "R6 status held then enabled", irq, 1);
    wr(3'd6, 32'd2);
    check(irq == 0, "R6 clear", irq, 0);

    for (int code = 0; code < 8; code++) begin
      setup(mk(1, 0, 0, 3'(code), 0, 2, 0, 0, 0), 1, 1, 1, 1);
      measure(0, st, w);
      check(st == 2, "R7 cpu pulse start", st, 2);
      check(w == expw(code), "R7 cpu pulse width", w, expw(code));
    end
    for (int code = 0; code < 8; code++) begin
      setup(mk(1, 0, 0, 0, 3'(code), 3, 0, 0, 0), 1, 1, 1, 1);
      measure(1, st, w);
      check(w == expw(code), "R7 sys pulse width", w, expw(code));
    end
    setup(mk(1, 0, 0, 0, 3'd2, 4, 0, 0, 0), 1, 1, 1, 1);
    measure(2, st, w);
    check(w == 60, "R7 aon pulse width", w, 60);

    setup(mk(1, 0, 0, 0, 0, 2, 2, 0, 0), 1, 1, 1, 1);
    hi = 0; rises = 0; prev = 0;
    for (int i = 0; i < 100; i++) begin
      if (cpu_rst) hi++;
      if (cpu_rst && !prev) rises++;
      prev = cpu_rst;
      @(negedge clk);
    end
    check(hi == 20, "R8 overlapping request dropped width", hi, 20);
    check(rises == 1, "R8 single pulse", rises, 1);

    setup(mk(1, 0, 1, 0, 0, 1, 0, 0, 0), 8, 1, 1, 1);
    idle(10);
    wr(3'd6, 32'd1);
    wait_irq(100, n);
    check(n == 16, "R9 feed restarts", n, 16);

    setup(mk(1, 0, 1, 0, 0, 1, 0, 0, 0), 8, 1, 1, 1);
    wr(3'd0, 32'd0);
    wr(3'd1, 32'd0);
    wr(3'd6, 32'd1);
    wait_irq(100, n);
    check(n + 3 == 16, "R9 R1 locked feed and ctrl ignored", n + 3, 16);
    wr(3'd0, KEY);

    setup(mk(1, 1, 1, 0, 0, 1, 0, 0, 0), 5, 1, 1, 1);
    sleep_in = 1; idle(7); sleep_in = 0;
    wait_irq(100, n);
    check(n == 10, "R10 pause in sleep", n, 10);
    setup(mk(1, 0, 1, 0, 0, 1, 0, 0, 0), 5, 1, 1, 1);
    sleep_in = 1;
    wait_irq(100, n);
    sleep_in = 0;
    check(n == 10, "R10 sleep ignored without pause", n, 10);

    setup(mk(1, 0, 1, 0, 0, 1, 0, 0, 0), 5, 1, 1, 1);
    idle(4);
    wr(3'd1, mk(0, 0, 1, 0, 0, 1, 0, 0, 0));
    idle(30);
    check(irq == 0, "R2 disabled holds", irq, 0);
    wr(3'd1, mk(1, 0, 1, 0, 0, 1, 0, 0, 0));
    wait_irq(100, n);
    check(n == 10, "R2 enable restarts from zero", n, 10);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule